// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block behaves as a byte-addressed serial EEPROM on a two-wire bus. A bus master addresses it with a select byte. The select byte holds a fixed family code, three bits that must equal the block's strapped select inputs, and a direction bit. The master then supplies a word address, and the block either collects data bytes for storage or returns stored bytes one after another. The data line is open-drain. The block only ever pulls it low through an output enable and never drives it high. Both bus wires are resampled by the system clock, so start, stop and clock edges are found as single-cycle events.

Written bytes first land in a page-sized staging buffer. They reach the array only when the master ends the transfer with a stop condition. A start condition that comes first throws the staged bytes away. A write-protect input stops any byte from being staged. The master still sees every byte acknowledged, but the array is left unchanged. The array holds a parameterised number of 32-byte pages. With the default 128 pages the word address is 12 bits wide.

Top module: `ee_two_wire_target`

## Requirements
- R1: Out of reset the data-line enable `sda_oe_o` is low, so the line is released.
- R2: The block acknowledges a select byte only if its upper nibble is 4'b1010 and bits [3:1] equal `sel_i`. Bit 0 gives the direction (1 = read). For any other select byte the block never pulls the line for the rest of that transfer, including during the following read bits.
- R3: The block samples incoming bits while SCL is high and changes outgoing bits only after SCL falls. A bit it drives stays constant for the whole high phase of SCL.
- R4: The word address arrives as two bytes, high byte first. In the high byte, bits above the array's address width are ignored.
- R5: A byte written at an address and committed by a stop is returned by a later random read. A random read is a write of the address, then a repeated start, then a read.
- R6: During a multi-byte write only address bits [4:0] advance, and they wrap inside the 32-byte page. A later byte that lands on an earlier position overwrites it. Bytes in other pages are untouched.
- R7: During a read the full word address advances after each byte and rolls over from the last location to address 0.
- R8: While `wp_i` is high, data bytes are still acknowledged but the array contents do not change.
- R9: A start condition before the stop discards every byte staged in the current write.
- R10: A read ends when the master does not acknowledge a byte. After that the block keeps the line released through the stop.
- R11: The select byte, both address bytes and every data byte of a write are acknowledged by pulling the line low during the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sampled level of the serial data line |
| sel_i | input | 3 | Strapped device-select value |
| wp_i | input | 1 | Write protect, high blocks all writes |
| sda_oe_o | output | 1 | Pulls the data line low when high |

## Verification
Some rules are checked by assertions on every cycle. The line may only begin to be pulled in the cycle after an SCL fall is detected. It is released after every stop. No byte is staged while a commit is draining. Each commit drains the whole staging buffer. The bench scenarios cover what needs a full transfer: select-value matching over all eight codes, address high-byte masking, page wrap with overwrite, address rollover on reads, write protection, and discarding a write cut off by a repeated start. Each scenario compares bytes read back against values worked out from the written pattern.

// File: rtl/ee_pkg.sv
package ee_pkg;
    localparam logic [3:0] FAMILY_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } rx_ph_e;
endpackage

// File: rtl/ee_bus_sense.sv
module ee_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic [1:0] scl_sh;
        logic [1:0] sda_sh;
        logic       scl_old;
        logic       sda_old;
    } sense_t;

    sense_t q, d;

    always_comb begin
        d         = q;
        d.scl_sh  = {q.scl_sh[0], scl_i};
        d.sda_sh  = {q.sda_sh[0], sda_i};
        d.scl_old = q.scl_sh[1];
        d.sda_old = q.sda_sh[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_bit   = q.sda_sh[1];
    assign scl_rise  = q.scl_sh[1] & ~q.scl_old;
    assign scl_fall  = ~q.scl_sh[1] & q.scl_old;
    assign bus_start = q.scl_sh[1] & q.scl_old & q.sda_old & ~q.sda_sh[1];
    assign bus_stop  = q.scl_sh[1] & q.scl_old & ~q.sda_old & q.sda_sh[1];
endmodule

// File: rtl/ee_page_store.sv
module ee_page_store #(
    parameter int AW         = 12,
    parameter int PAGE_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-$clog2(PAGE_BYTES)-1:0] wr_page,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_off,
    input  logic [7:0]                    wr_data,
    input  logic                          clear,
    input  logic                          commit,
    output logic                          busy,
    input  logic [AW-1:0]                 rd_addr,
    output logic [7:0]                    rd_data
);
    localparam int OW    = $clog2(PAGE_BYTES);
    localparam int PW    = AW - OW;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PAGE_BYTES-1:0] valid;
        logic [PW-1:0]         page;
        logic                  busy;
        logic [OW-1:0]         idx;
    } store_t;

    store_t     q, d;
    logic       mem_we;
    logic [7:0] pbuf_q [PAGE_BYTES];
    logic [7:0] mem_q  [DEPTH];

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (q.busy) begin
            mem_we         = q.valid[q.idx];
            d.valid[q.idx] = 1'b0;
            d.idx          = q.idx + 1'b1;
            if (q.idx == OW'(PAGE_BYTES - 1)) d.busy = 1'b0;
        end else if (clear) begin
            d.valid = '0;
        end else if (commit && (|q.valid)) begin
            d.busy = 1'b1;
            d.idx  = '0;
        end else if (wr_en) begin
            d.valid[wr_off] = 1'b1;
            d.page          = wr_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !q.busy) pbuf_q[wr_off] <= wr_data;
        if (mem_we) mem_q[{q.page, q.idx}] <= pbuf_q[q.idx];
    end

    assign busy    = q.busy;
    assign rd_data = mem_q[rd_addr];

    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !wr_en); // R6
    AST_COMMIT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (q.valid == '0)); // R9
endmodule

// File: rtl/ee_two_wire_target.sv
module ee_two_wire_target #(
    parameter int PAGES      = 128,
    parameter int PAGE_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    import ee_pkg::*;

    localparam int AW = $clog2(PAGES * PAGE_BYTES);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam int PW = AW - OW;

    typedef struct packed {
        bus_st_e       st;
        rx_ph_e        ph;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [AW-1:0] addr;
        logic          oe;
        logic          rd;
    } ctl_t;

    ctl_t       q, d;
    logic       sda_bit, scl_rise, scl_fall, bus_start, bus_stop;
    logic       wr_en, clr, cmt, busy;
    logic [7:0] rd_data;

    ee_bus_sense i_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    ee_page_store #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_page (q.addr[AW-1:OW]),
        .wr_off  (q.addr[OW-1:0]),
        .wr_data (q.sh),
        .clear   (clr),
        .commit  (cmt),
        .busy    (busy),
        .rd_addr (q.addr),
        .rd_data (rd_data)
    );

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        clr   = 1'b0;
        cmt   = 1'b0;
        if (bus_start) begin
            d.st  = ST_RX;
            d.ph  = PH_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
            clr   = 1'b1;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
            cmt  = 1'b1;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_bit};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.st = ST_ACK;
                        d.oe = 1'b1;
                        unique case (q.ph)
                            PH_DEV: begin
                                if (q.sh[7:4] == FAMILY_CODE && q.sh[3:1] == sel_i && !busy) begin
                                    d.rd = q.sh[0];
                                    d.ph = PH_AHI;
                                end else begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            PH_AHI: begin
                                d.addr[AW-1:8] = q.sh[AW-9:0];
                                d.ph           = PH_ALO;
                            end
                            PH_ALO: begin
                                d.addr[7:0] = q.sh;
                                d.ph        = PH_DATA;
                            end
                            default: begin
                                wr_en           = !wp_i;
                                d.addr[OW-1:0]  = q.addr[OW-1:0] + 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.st = ST_TX;
                            d.sh = rd_data;
                            d.oe = ~rd_data[7];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe   = 1'b0;
                            d.st   = ST_RACK;
                            d.addr = q.addr + 1'b1;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && sda_bit) begin
                        d.st = ST_IDLE;
                    end else if (scl_fall) begin
                        d.st  = ST_TX;
                        d.cnt = '0;
                        d.sh  = rd_data;
                        d.oe  = ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ph   <= PH_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall)); // R3
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_stop) |-> !sda_oe_o); // R10
endmodule

// File: tb/test_ee_two_wire_target.sv
module test_ee_two_wire_target;
    localparam logic [2:0] MY_SEL = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] sel = MY_SEL;
    logic       sda_oe;
    logic       sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int r3_unstable = 0;
    logic [7:0] wbuf [40];
    logic [7:0] rbuf [40];

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    ee_two_wire_target i_ee_two_wire_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sel_i    (sel),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b0; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b1; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, output int ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw();
            scl_m = 1'b1; hw();
            scl_m = 1'b0; hw();
        end
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        ack = (sda_line == 1'b0) ? 1 : 0;
        scl_m = 1'b0; hw();
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        logic early;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw();
            scl_m = 1'b1;
            repeat (2) @(negedge clk);
            early = sda_line;
            repeat (8) @(negedge clk);
            b[i] = sda_line;
            if (early !== b[i]) r3_unstable++;
            scl_m = 1'b0;
        end
        sda_m = ack ? 1'b0 : 1'b1; hw();
        scl_m = 1'b1; hw();
        scl_m = 1'b0; hw();
        sda_m = 1'b1;
    endtask

    task automatic send_addr(input logic [7:0] hi, input logic [7:0] lo, output int acks);
        int a;
        acks = 0;
        bus_start();
        send_byte({4'b1010, MY_SEL, 1'b0}, a); acks += a;
        send_byte(hi, a); acks += a;
        send_byte(lo, a); acks += a;
    endtask

    task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
        int acks;
        int a;
        send_addr(hi, lo, acks);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            acks += a;
        end
        bus_stop();
        repeat (80) @(negedge clk);
        chk({req, " R11 write acks"}, acks, n + 3);
    endtask

    task automatic do_read(input logic [7:0] hi, input logic [7:0] lo, input int n);
        int acks;
        int a;
        send_addr(hi, lo, acks);
        bus_start();
        send_byte({4'b1010, MY_SEL, 1'b1}, a);
        acks += a;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        chk("R10 released after nack", int'(sda_oe), 0);
        bus_stop();
        chk("R10 released after stop", int'(sda_oe), 0);
        chk("R11 read setup acks", acks, 4);
    endtask

    initial begin
        int a;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        chk("R1 reset release", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle release", int'(sda_oe), 0);

        // R2: sweep all select values against the strap
        for (int s = 0; s < 8; s++) begin
            bus_start();
            send_byte({4'b1010, 3'(s), 1'b0}, a);
            bus_stop();
            chk($sformatf("R2 select %0d", s), a, (s == int'(MY_SEL)) ? 1 : 0);
        end
        bus_start();
        send_byte({4'b1011, MY_SEL, 1'b0}, a);
        bus_stop();
        chk("R2 wrong family code", a, 0);
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b1}, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R2 foreign read not acked", a, 0);
        chk("R2 foreign read line idle", int'(b), 8'hFF);

        // R5: byte write then random read
        wbuf[0] = 8'hA5;
        do_write(8'h01, 8'h23, 1, "R5");
        do_read(8'h01, 8'h23, 1);
        chk("R5 random read", int'(rbuf[0]), 8'hA5);

        // R4: junk in upper address bits is ignored
        wbuf[0] = 8'h3C;
        do_write(8'hF3, 8'h45, 1, "R4");
        do_read(8'h03, 8'h45, 1);
        chk("R4 masked high byte", int'(rbuf[0]), 8'h3C);

        // R6: 34 bytes from offset 0x10 of page 5 wrap within the page
        for (int k = 0; k < 34; k++) wbuf[k] = 8'(8'h40 + k);
        wbuf[0] = 8'h11; wbuf[1] = 8'h12;
        wbuf[0] = 8'h40; wbuf[1] = 8'h41;
        do_write(8'h00, 8'hB0, 34, "R6");
        do_read(8'h00, 8'hA0, 32);
        for (int off = 0; off < 32; off++) begin
            int k;
            k = (off - 16) & 31;
            if (k < 2) k += 32;
            chk($sformatf("R6 page offset %0d", off), int'(rbuf[off]), 8'h40 + k);
        end
        do_read(8'h00, 8'hC0, 1);
        chk("R6 next page untouched", int'(rbuf[0]) == 8'h40 + 16 ? 1 : 0, 0);

        // R7: sequential read across the top of the array
        wbuf[0] = 8'h5A;
        do_write(8'h0F, 8'hFF, 1, "R7");
        wbuf[0] = 8'h6B; wbuf[1] = 8'h7C;
        do_write(8'h00, 8'h00, 2, "R7");
        do_read(8'h0F, 8'hFF, 3);
        chk("R7 last location", int'(rbuf[0]), 8'h5A);
        chk("R7 rollover to 0", int'(rbuf[1]), 8'h6B);
        chk("R7 address 1", int'(rbuf[2]), 8'h7C);

        // R8: write protect keeps the array unchanged
        wp = 1'b1;
        wbuf[0] = 8'h77; wbuf[1] = 8'h78;
        do_write(8'h01, 8'h23, 2, "R8");
        do_read(8'h01, 8'h23, 2);
        chk("R8 protected byte 0", int'(rbuf[0]), 8'hA5);
        chk("R8 protected byte 1 not 0x78", (rbuf[1] == 8'h78) ? 1 : 0, 0);
        wp = 1'b0;

        // R9: repeated start before stop discards staged bytes
        wbuf[0] = 8'h55;
        do_write(8'h02, 8'h00, 1, "R9");
        send_addr(8'h02, 8'h00, a);
        send_byte(8'h99, a);
        chk("R11 data ack before abort", a, 1);
        bus_start();
        bus_stop();
        repeat (80) @(negedge clk);
        do_read(8'h02, 8'h00, 1);
        chk("R9 aborted write discarded", int'(rbuf[0]), 8'h55);

        chk("R3 read bits stable while SCL high", r3_unstable, 0);
        chk("R1 final release", int'(sda_oe), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule